// File: doc/BRIEF.md
# Largest-First Hybrid Statistics Counter Manager

This block holds a bank of wide statistics counters. Each counter is split into two parts. A narrow fast part takes the increments. A wide backing part holds the bulk of the count. The backing store allows only one read-modify-write per slow period of `SLOW_DIV` cycles, so the block is a model of a dense, slow memory placed behind a small, fast one. An update port can add one to any counter in each cycle. Traffic that hits several counters for one packet is fed in as a series of single increments.

Once per slow period a flush engine looks at all fast parts. It picks the one that holds the largest value, adds that value into the counter's backing entry, and clears the fast part. Because the largest fast part is always drained first, a small fast width is enough for any traffic pattern. A sticky flag records any increment that would have wrapped a fast part. The read port returns the full count, which is the backing part plus the fast part, one cycle after the request.

Top module: `ctr_hybrid_mgr`

## Requirements
- R1: While reset is asserted, every counter total is cleared to zero, and `rd_valid`, `flush_fire` and `ovf_sticky` are low. After reset the slow-period counter starts again from zero.
- R2: Each cycle with `upd_en` high adds exactly one to the total of counter `upd_idx`.
- R3: A cycle with `rd_en` high gives `rd_valid` high in the next cycle. `rd_data` then holds the total of counter `rd_idx` as it stood before the update applied in the same edge as the request.
- R4: `flush_fire` is high only in the last cycle of a slow period. This is the cycle in which the period counter equals `SLOW_DIV-1`, so the first chance is the fourth cycle after reset with `SLOW_DIV`=4. It is never high in two cycles that follow each other.
- R5: When `flush_fire` is high, `flush_idx` names a counter whose fast part is the largest of all the fast parts.
- R6: When several fast parts share that largest value, `flush_idx` is the lowest of their indices.
- R7: A flush moves the fast value into the backing part and leaves every total unchanged. If an increment hits the counter being flushed in the same cycle, the fast part becomes 1 and no count is lost.
- R8: In a flush slot where every fast part is zero, `flush_fire` stays low.
- R9: An increment to a fast part that is at its all-ones value, and that is not being flushed in that cycle, sets `ovf_sticky`. The fast part stays saturated. The flag stays high until reset.
- R10: With the default sizing (16 counters, `SLOW_DIV`=4, 4-bit fast parts), `ovf_sticky` never sets, whatever the update pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| upd_en | input | 1 | Add one to the selected counter |
| upd_idx | input | IDX_W | Index of the counter to add to |
| rd_en | input | 1 | Read request |
| rd_idx | input | IDX_W | Index of the counter to read |
| rd_valid | output | 1 | `rd_data` is valid in this cycle |
| rd_data | output | FULL_W | Full count (backing part plus fast part) |
| flush_fire | output | 1 | A flush is applied at the coming edge |
| flush_idx | output | IDX_W | Counter chosen for that flush |
| ovf_sticky | output | 1 | A fast part was asked to go past its all-ones value |

## Verification
The bench drives increments into a counter in the very cycle that counter is flushed. A design that cleared the fast part without keeping the new increment would then read one low. Tie tests leave two counters with equal fast values, and unequal tests leave one counter clearly ahead. A picker that favoured the upper index, or took the first nonzero entry, would name the wrong counter in `flush_idx`. Empty flush slots and the first slot after reset are checked, to catch a timer that fires early or a flush that runs on zero. A second instance has a narrow fast part and a long period. It is used to force saturation and to check that the flag stays set and that the total stays at the all-ones value. A long run of random traffic, followed by traffic that narrows onto fewer and fewer counters, shows that the default sizing never overflows and that reads agree with the model after every flush.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

  // Width of a counter index; a single counter still gets one bit.
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ctr_flush_timer.sv
module ctr_flush_timer #(
  parameter int SLOW_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic slot_go
);

  localparam int CNT_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOW_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign slot_go = (cnt_q == LAST);

  AST_FLUSH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    slot_go |=> !slot_go); // R4

endmodule

// File: rtl/ctr_max_pick.sv
module ctr_max_pick #(
  parameter int N_CTR  = 16,
  parameter int FAST_W = 4,
  parameter int IDX_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_CTR*FAST_W-1:0] fast_flat,
  output logic [FAST_W-1:0]       best_val,
  output logic [IDX_W-1:0]        best_idx
);

  localparam int LEAVES = 1 << IDX_W;

  // Binary tree; the lower-index side wins on equal values.
  for (genvar l = 0; l <= IDX_W; l++) begin : g_lvl
    localparam int W = LEAVES >> l;
    logic [FAST_W-1:0] v  [W];
    logic [IDX_W-1:0]  ix [W];
    for (genvar k = 0; k < W; k++) begin : g_n
      if (l == 0) begin : g_leaf
        if (k < N_CTR) begin : g_real
          assign v[k] = fast_flat[k*FAST_W +: FAST_W];
        end else begin : g_pad
          assign v[k] = '0;
        end
        assign ix[k] = IDX_W'(k);
      end else begin : g_cmp
        logic take_lo;
        assign take_lo = (g_lvl[l-1].v[2*k] >= g_lvl[l-1].v[2*k+1]);
        assign v[k]    = take_lo ? g_lvl[l-1].v[2*k]  : g_lvl[l-1].v[2*k+1];
        assign ix[k]   = take_lo ? g_lvl[l-1].ix[2*k] : g_lvl[l-1].ix[2*k+1];
      end
    end
  end

  assign best_val = g_lvl[IDX_W].v[0];
  assign best_idx = g_lvl[IDX_W].ix[0];

  always @(posedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < N_CTR; k++) begin
        AST_PICK_MAX: assert (fast_flat[k*FAST_W +: FAST_W] <= best_val); // R5
        if (k < int'(best_idx)) begin
          AST_PICK_LOWEST: assert (fast_flat[k*FAST_W +: FAST_W] < best_val); // R6
        end
      end
    end
  end

endmodule

// File: rtl/ctr_fast_bank.sv
module ctr_fast_bank #(
  parameter int N_CTR  = 16,
  parameter int FAST_W = 4,
  parameter int IDX_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inc_en,
  input  logic [IDX_W-1:0]        inc_idx,
  input  logic                    clr_en,
  input  logic [IDX_W-1:0]        clr_idx,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [FAST_W-1:0]       rd_fast,
  output logic [N_CTR*FAST_W-1:0] fast_flat,
  output logic                    ovf_sticky
);

  localparam logic [FAST_W-1:0] FAST_MAX = '1;

  logic [FAST_W-1:0] fast_q [N_CTR];
  logic [FAST_W-1:0] fast_d [N_CTR];
  logic              ovf_q, ovf_d, ovf_hit;

  always_comb begin
    ovf_hit = 1'b0;
    for (int i = 0; i < N_CTR; i++) begin
      logic hit_inc, hit_clr;
      hit_inc = inc_en && (inc_idx == IDX_W'(i));
      hit_clr = clr_en && (clr_idx == IDX_W'(i));
      if (hit_clr) begin
        fast_d[i] = hit_inc ? FAST_W'(1) : '0;
      end else if (hit_inc) begin
        if (fast_q[i] == FAST_MAX) begin
          fast_d[i] = fast_q[i];
          ovf_hit   = 1'b1;
        end else begin
          fast_d[i] = fast_q[i] + FAST_W'(1);
        end
      end else begin
        fast_d[i] = fast_q[i];
      end
    end
    ovf_d = ovf_q | ovf_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CTR; i++) fast_q[i] <= '0;
      ovf_q <= 1'b0;
    end else begin
      for (int i = 0; i < N_CTR; i++) fast_q[i] <= fast_d[i];
      ovf_q <= ovf_d;
    end
  end

  always_comb begin
    rd_fast = '0;
    for (int i = 0; i < N_CTR; i++) begin
      if (rd_idx == IDX_W'(i)) rd_fast = fast_q[i];
    end
  end

  for (genvar g = 0; g < N_CTR; g++) begin : g_flat
    assign fast_flat[g*FAST_W +: FAST_W] = fast_q[g];
  end

  assign ovf_sticky = ovf_q;

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(inc_en && inc_idx == clr_idx)) |=> (fast_q[$past(clr_idx)] == '0)); // R7
  AST_FLUSH_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && inc_en && inc_idx == clr_idx) |=> (fast_q[$past(clr_idx)] == FAST_W'(1))); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R9

endmodule

// File: rtl/ctr_slow_bank.sv
module ctr_slow_bank #(
  parameter int N_CTR  = 16,
  parameter int FULL_W = 32,
  parameter int FAST_W = 4,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [FAST_W-1:0] wr_add,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [FULL_W-1:0] rd_slow
);

  logic [FULL_W-1:0] slow_q [N_CTR];
  logic [FULL_W-1:0] slow_d [N_CTR];

  always_comb begin
    for (int i = 0; i < N_CTR; i++) begin
      if (wr_en && (wr_idx == IDX_W'(i))) slow_d[i] = slow_q[i] + FULL_W'(wr_add);
      else                                slow_d[i] = slow_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CTR; i++) slow_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_CTR; i++) slow_q[i] <= slow_d[i];
    end
  end

  always_comb begin
    rd_slow = '0;
    for (int i = 0; i < N_CTR; i++) begin
      if (rd_idx == IDX_W'(i)) rd_slow = slow_q[i];
    end
  end

  AST_BACKING_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (slow_q[$past(wr_idx)] == $past(slow_q[wr_idx]) + FULL_W'($past(wr_add)))); // R7

endmodule

// File: rtl/ctr_hybrid_mgr.sv
module ctr_hybrid_mgr
  import ctr_pkg::*;
#(
  parameter int N_CTR    = 16,
  parameter int SLOW_DIV = 4,
  parameter int FAST_W   = 4,
  parameter int FULL_W   = 32,
  localparam int IDX_W   = idx_bits(N_CTR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [FULL_W-1:0] rd_data,
  output logic              flush_fire,
  output logic [IDX_W-1:0]  flush_idx,
  output logic              ovf_sticky
);

  logic                    slot_go;
  logic [N_CTR*FAST_W-1:0] fast_flat;
  logic [FAST_W-1:0]       best_val, rd_fast;
  logic [IDX_W-1:0]        best_idx;
  logic [FULL_W-1:0]       rd_slow;
  logic                    rd_valid_q, rd_valid_d;
  logic [FULL_W-1:0]       rd_data_q, rd_data_d;

  ctr_flush_timer #(.SLOW_DIV(SLOW_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .slot_go(slot_go)
  );

  ctr_max_pick #(.N_CTR(N_CTR), .FAST_W(FAST_W), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .fast_flat(fast_flat),
    .best_val(best_val), .best_idx(best_idx)
  );

  // An empty flush slot is skipped.
  assign flush_fire = slot_go && (best_val != '0);
  assign flush_idx  = best_idx;

  ctr_fast_bank #(.N_CTR(N_CTR), .FAST_W(FAST_W), .IDX_W(IDX_W)) u_fast (
    .clk(clk), .rst_n(rst_n),
    .inc_en(upd_en), .inc_idx(upd_idx),
    .clr_en(flush_fire), .clr_idx(best_idx),
    .rd_idx(rd_idx), .rd_fast(rd_fast),
    .fast_flat(fast_flat), .ovf_sticky(ovf_sticky)
  );

  ctr_slow_bank #(.N_CTR(N_CTR), .FULL_W(FULL_W), .FAST_W(FAST_W), .IDX_W(IDX_W)) u_slow (
    .clk(clk), .rst_n(rst_n),
    .wr_en(flush_fire), .wr_idx(best_idx), .wr_add(best_val),
    .rd_idx(rd_idx), .rd_slow(rd_slow)
  );

  always_comb begin
    rd_valid_d = rd_en;
    rd_data_d  = rd_en ? (rd_slow + FULL_W'(rd_fast)) : rd_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_valid_d;
      rd_data_q  <= rd_data_d;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R3
  AST_FLUSH_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    flush_fire |-> (fast_flat[int'(flush_idx)*FAST_W +: FAST_W] != '0)); // R8
  AST_FLUSH_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    flush_fire |=> !flush_fire); // R4

endmodule

// File: tb/sim_ctr_hybrid_mgr.sv
module sim_ctr_hybrid_mgr;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 16;
  localparam int FW         = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          upd_en = 1'b0, rd_en = 1'b0;
  logic [3:0]    upd_idx = '0, rd_idx = '0;
  logic          rd_valid, flush_fire, ovf_sticky;
  logic [FW-1:0] rd_data;
  logic [3:0]    flush_idx;

  logic          b_upd_en = 1'b0, b_rd_en = 1'b0;
  logic [3:0]    b_upd_idx = '0, b_rd_idx = '0;
  logic          b_rd_valid, b_flush_fire, b_ovf;
  logic [FW-1:0] b_rd_data;
  logic [3:0]    b_flush_idx;

  int            checks = 0, errors = 0;
  longint        mdl [N];
  longint        exp_q [$];
  logic [15:0]   lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctr_hybrid_mgr u0 (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_idx(upd_idx),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data),
    .flush_fire(flush_fire), .flush_idx(flush_idx), .ovf_sticky(ovf_sticky)
  );

  // Narrow fast part and long period, so that saturation can be forced.
  ctr_hybrid_mgr #(.SLOW_DIV(8), .FAST_W(2)) u1 (
    .clk(clk), .rst_n(rst_n), .upd_en(b_upd_en), .upd_idx(b_upd_idx),
    .rd_en(b_rd_en), .rd_idx(b_rd_idx), .rd_valid(b_rd_valid), .rd_data(b_rd_data),
    .flush_fire(b_flush_fire), .flush_idx(b_flush_idx), .ovf_sticky(b_ovf)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // The caller starts at a falling edge; the task returns at the next one.
  task automatic step(input bit inc, input int iidx, input bit rd, input int ridx);
    upd_en  = inc;
    upd_idx = 4'(iidx);
    rd_en   = rd;
    rd_idx  = 4'(ridx);
    if (rd)  exp_q.push_back(mdl[ridx]);
    if (inc) mdl[iidx]++;
    @(posedge clk);
    @(negedge clk);
    upd_en = 1'b0;
    rd_en  = 1'b0;
  endtask

  task automatic step_b(input bit inc, input bit rd);
    b_upd_en = inc;
    b_rd_en  = rd;
    @(posedge clk);
    @(negedge clk);
    b_upd_en = 1'b0;
    b_rd_en  = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int i = 0; i < N; i++) mdl[i] = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Scoreboard monitor (R2, R3, R7)
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected rd_valid", 1, 0);
      end else begin
        longint e;
        e = exp_q.pop_front();
        chk(longint'(rd_data) == e, "R2/R3/R7 read total", longint'(rd_data), e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    chk(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);
    chk(flush_fire == 1'b0, "R1 flush_fire after reset", flush_fire, 0);
    chk(ovf_sticky == 1'b0, "R1 ovf after reset", ovf_sticky, 0);
    chk(b_ovf == 1'b0, "R1 u1 ovf after reset", b_ovf, 0);
    for (int i = 0; i < N; i++) step(0, 0, 1, i);
    step(0, 0, 0, 0);

    // R8: empty slot does not fire
    do_reset();
    step(0, 0, 0, 0); step(0, 0, 0, 0); step(0, 0, 0, 0);
    chk(flush_fire == 1'b0, "R8 empty slot", flush_fire, 0);

    // R4 and R6: first slot after reset, tie goes to the lower index
    do_reset();
    step(1, 9, 0, 0);
    step(1, 3, 0, 0);
    chk(flush_fire == 1'b0, "R4 no flush before slot", flush_fire, 0);
    step(0, 0, 0, 0);
    chk(flush_fire == 1'b1, "R4 flush in last cycle of period", flush_fire, 1);
    chk(flush_idx == 4'd3, "R6 tie picks lower index", flush_idx, 3);
    step(0, 0, 0, 0);
    chk(flush_fire == 1'b0, "R4 no back-to-back flush", flush_fire, 0);
    step(0, 0, 0, 0); step(0, 0, 0, 0); step(0, 0, 0, 0);
    chk(flush_fire == 1'b1 && flush_idx == 4'd9, "R6 next flush takes the remaining counter", flush_idx, 9);
    step(0, 0, 0, 0);
    step(0, 0, 1, 3); step(0, 0, 1, 9); step(0, 0, 1, 0);  // R7 totals kept
    step(0, 0, 0, 0);

    // R5: largest fast part wins
    do_reset();
    step(1, 2, 0, 0);
    step(1, 7, 0, 0);
    step(1, 7, 0, 0);
    chk(flush_fire == 1'b1 && flush_idx == 4'd7, "R5 largest picked", flush_idx, 7);
    step(0, 0, 0, 0); step(0, 0, 0, 0); step(0, 0, 0, 0); step(0, 0, 0, 0);
    chk(flush_fire == 1'b1 && flush_idx == 4'd2, "R5 second flush", flush_idx, 2);
    step(0, 0, 0, 0);
    step(0, 0, 1, 7); step(0, 0, 1, 2);
    step(0, 0, 0, 0);

    // R7: increment in the same cycle as the flush of that counter
    do_reset();
    for (int c = 0; c < 6; c++) step(1, 5, 0, 0);
    step(0, 0, 1, 5);
    step(0, 0, 0, 0);

    // R9: saturation on the narrow instance
    do_reset();
    step_b(1, 0); step_b(1, 0); step_b(1, 0);
    chk(b_ovf == 1'b0, "R9 no flag below all-ones", b_ovf, 0);
    step_b(1, 0);
    chk(b_ovf == 1'b1, "R9 flag set on saturation", b_ovf, 1);
    step_b(0, 0); step_b(0, 0); step_b(0, 0); step_b(0, 0);
    step_b(0, 1);
    chk(b_rd_valid == 1'b1 && b_rd_data == 32'd3, "R9 total held at all-ones", longint'(b_rd_data), 3);
    chk(b_ovf == 1'b1, "R9 flag is sticky", b_ovf, 1);

    // R10: long random, then narrowing traffic on the default sizing
    do_reset();
    for (int c = 0; c < 1500; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(1, int'(lfsr[3:0]), lfsr[7:5] == 3'd0, int'(lfsr[11:8]));
    end
    for (int c = 0; c < 1000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(1, c % (16 - c / 70), lfsr[7:5] == 3'd0, int'(lfsr[11:8]));
    end
    for (int i = 0; i < N; i++) step(0, 0, 1, i);
    step(0, 0, 0, 0);
    chk(ovf_sticky == 1'b0, "R10 no overflow at default sizing", ovf_sticky, 0);
    chk(exp_q.size() == 0, "R3 all reads answered", exp_q.size(), 0);

    summary();
    $finish;
  end

endmodule